// File: doc/BRIEF.md
# Conditional-Sum Magnitude Comparator

This block decides whether one unsigned operand is at least as large as another without building a subtractor. It treats the comparison as the carry-out of `a + ~b + 1`. It computes only that carry. No sum bits are formed.

Each bit position first produces two candidate carries: one for an incoming carry of 0 (`a & ~b`) and one for an incoming carry of 1 (`a | ~b`). A tree of 2-to-1 multiplexers then merges neighbouring groups level by level. The lowest group is always resolved against the fixed carry-in of 1. Its resolved carry selects between the two candidates of the group above it. At the top of the tree only the final carry remains, and that carry is the flag.

Alongside the flag, the block steers the operands for a following absolute-difference adder. It passes the larger operand through unchanged and presents the ones' complement of the smaller one. Adding those two with a carry-in of 1 yields `|a - b|`. The block is purely combinational.

Top module: `mag_cmp_csel`

## Requirements
- R1: `ge` is 1 whenever `a` is strictly greater than `b`, with both taken as unsigned `WIDTH`-bit numbers.
- R2: `ge` is 1 when `a` equals `b`, including both all-zero and both all-one.
- R3: `ge` is 0 whenever `a` is strictly less than `b`.
- R4: `big` equals `a` when `ge` is 1 and equals `b` when `ge` is 0.
- R5: `small_inv` equals the bitwise inversion of `b` when `ge` is 1 and the bitwise inversion of `a` when `ge` is 0.
- R6: `big + small_inv + 1`, truncated to `WIDTH` bits, equals the absolute difference of `a` and `b`.
- R7: The block holds no state. All outputs depend only on the present `a` and `b` and settle within the same cycle the inputs change.
- R8: With 8-bit operands, `a=84, b=67` gives `ge=1`; `a=84, b=84` gives `ge=1`; `a=67, b=84` gives `ge=0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| ge | output | 1 | 1 when a is greater than or equal to b |
| big | output | WIDTH | Larger operand, passed through unchanged |
| small_inv | output | WIDTH | Ones' complement of the smaller operand |

## Verification
The bench builds the block with its default `WIDTH` of 8. At that width every one of the 65,536 operand pairs can be applied, one pair per cycle, inside the run budget. This exhaustive sweep reaches every selection path through the three mux levels: equal operands, pairs that differ only in the lowest bit, and pairs that differ only in the highest bit. Three directed pairs from the requirements and an all-zero pair are applied ahead of the sweep.

// File: rtl/csc_pkg.sv
package csc_pkg;

    // Carry-in applied to the lowest group: turns "a > b" into "a >= b".
    localparam logic CMP_CIN = 1'b1;

    // Candidate carries of a group: c0 for carry-in 0, c1 for carry-in 1.
    typedef struct packed {
        logic c0;
        logic c1;
    } cpair_t;

    // Merge a higher group over a lower one: the lower group's carry for
    // each assumption selects the higher group's matching outcome.
    function automatic cpair_t merge(input cpair_t hi, input cpair_t lo);
        cpair_t r;
        r.c0 = lo.c0 ? hi.c1 : hi.c0;
        r.c1 = lo.c1 ? hi.c1 : hi.c0;
        return r;
    endfunction

    // Resolve a group's carry once its true incoming carry is known.
    function automatic logic pick(input cpair_t p, input logic cin);
        return cin ? p.c1 : p.c0;
    endfunction

    // Offset of the unresolved groups of tree level k in the flat pair store.
    function automatic int pofs(input int k, input int w);
        int s;
        s = 0;
        for (int i = 0; i < k; i++) begin
            s += (w >> i) - 1;
        end
        return s;
    endfunction

endpackage

// File: rtl/csc_bitgen.sv
module csc_bitgen #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] nb,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    // Stage 0: one inverter and the two candidate carries per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign nb[i]   = ~b[i];
        assign gen[i]  = a[i] & nb[i];
        assign prop[i] = a[i] | nb[i];
    end
endmodule

// File: rtl/csc_tree.sv
module csc_tree
    import csc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] prop,
    output logic             carry
);
    localparam int LVLS = $clog2(WIDTH);
    localparam int NP   = pofs(LVLS, WIDTH);

    if ((1 << LVLS) != WIDTH || WIDTH < 2) begin : g_bad_width
        $error("csc_tree: WIDTH must be a power of two, at least 2");
    end

    // Unresolved groups (index 1 and up) of levels 0..LVLS-1.
    cpair_t          pr  [NP];
    // Resolved carry of group 0 at each level.
    logic [LVLS:0]   res;

    // Level 0: bit 0 resolved straight from the fixed carry-in.
    assign res[0] = CMP_CIN ? prop[0] : gen[0];
    for (genvar j = 1; j < WIDTH; j++) begin : g_l0
        assign pr[j-1] = '{c0: gen[j], c1: prop[j]};
    end

    for (genvar k = 1; k <= LVLS; k++) begin : g_lvl
        localparam int PREV = pofs(k - 1, WIDTH);
        localparam int CUR  = pofs(k, WIDTH);
        localparam int NG   = WIDTH >> k;

        // Group 0: one mux, picks from previous group 1.
        assign res[k] = pick(pr[PREV], res[k-1]);

        // Other groups: two muxes each, both assumptions kept.
        for (genvar j = 1; j < NG; j++) begin : g_grp
            assign pr[CUR + j - 1] = merge(pr[PREV + 2*j], pr[PREV + 2*j - 1]);
        end
    end

    assign carry = res[LVLS];
endmodule

// File: rtl/csc_steer.sv
module csc_steer #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] nb,
    input  logic             sel_a,
    output logic [WIDTH-1:0] big,
    output logic [WIDTH-1:0] small_inv
);
    always_comb begin
        if (sel_a) begin
            big       = a;
            small_inv = nb;
        end else begin
            big       = b;
            small_inv = ~a;
        end
    end
endmodule

// File: rtl/mag_cmp_csel.sv
module mag_cmp_csel #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             ge,
    output logic [WIDTH-1:0] big,
    output logic [WIDTH-1:0] small_inv
);
    logic [WIDTH-1:0] nb;
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;

    csc_bitgen #(.WIDTH(WIDTH)) u_bitgen (
        .a    (a),
        .b    (b),
        .nb   (nb),
        .gen  (gen),
        .prop (prop)
    );

    csc_tree #(.WIDTH(WIDTH)) u_tree (
        .gen   (gen),
        .prop  (prop),
        .carry (ge)
    );

    csc_steer #(.WIDTH(WIDTH)) u_steer (
        .a         (a),
        .b         (b),
        .nb        (nb),
        .sel_a     (ge),
        .big       (big),
        .small_inv (small_inv)
    );
endmodule

// File: rtl/mag_cmp_csel_chk.sv
module mag_cmp_csel_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             ge,
    input logic [WIDTH-1:0] big,
    input logic [WIDTH-1:0] small_inv
);
    logic [WIDTH-1:0] small_v;
    logic [WIDTH-1:0] span;
    assign small_v = ~small_inv;
    assign span    = big + small_inv + 1'b1;

    always_comb begin
        // R1
        gt_flag_chk: assert (!(a > b) || ge);
        // R2
        eq_flag_chk: assert (!(a == b) || ge);
        // R3
        lt_flag_chk: assert (!(a < b) || !ge);
        // R4
        big_pick_chk: assert ((big == a && small_v == b) || (big == b && small_v == a));
        // R5
        order_chk: assert (small_v <= big);
        // R6
        absdiff_chk: assert (span == ((a >= b) ? a - b : b - a));
    end
endmodule

bind mag_cmp_csel mag_cmp_csel_chk #(.WIDTH(WIDTH)) u_chk (
    .a         (a),
    .b         (b),
    .ge        (ge),
    .big       (big),
    .small_inv (small_inv)
);

// File: tb/sim_mag_cmp_csel.sv
`timescale 1ns/1ps
module sim_mag_cmp_csel;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ge;
    logic [W-1:0] big;
    logic [W-1:0] small_inv;

    mag_cmp_csel #(.WIDTH(W)) u0 (
        .a         (a),
        .b         (b),
        .ge        (ge),
        .big       (big),
        .small_inv (small_inv)
    );

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         ge;
        logic [W-1:0] big;
        logic [W-1:0] sinv;
        logic [W-1:0] diff;
        string        tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
        end
    endtask

    // Driver: apply operands and push the expected results.
    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        item_t it;
        @(negedge clk);
        a = x;
        b = y;
        it.a    = x;
        it.b    = y;
        it.ge   = (x >= y);
        it.big  = (x >= y) ? x : y;
        it.sinv = (x >= y) ? ~y : ~x;
        it.diff = (x >= y) ? x - y : y - x;
        it.tag  = tag;
        q.push_back(it);
    endtask

    // Monitor: 1 ns after the driving edge, well before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [W-1:0] span;
                string flag_req;
                it = q.pop_front();
                span = big + small_inv + 1'b1;
                if (it.tag != "")        flag_req = it.tag;
                else if (it.a == it.b)   flag_req = "R2";
                else if (it.a < it.b)    flag_req = "R3";
                else                     flag_req = "R1";
                chk(flag_req, int'(ge), int'(it.ge));
                chk("R4", int'(big), int'(it.big));
                chk("R5", int'(small_inv), int'(it.sinv));
                chk("R6", int'(span), int'(it.diff));
            end
        end
    end

    initial begin
        rst = 1'b1;
        a = '0;
        b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R7: output is a pure function of the inputs right out of reset
        drive(8'd0, 8'd0, "R7");
        // R8: worked example pairs
        drive(8'd84, 8'd67, "R8");
        drive(8'd84, 8'd84, "R8");
        drive(8'd67, 8'd84, "R8");
        // R1 R2 R3 R4 R5 R6: exhaustive sweep
        for (int x = 0; x < (1 << W); x++) begin
            for (int y = 0; y < (1 << W); y++) begin
                drive(W'(x), W'(y), "");
            end
        end
        repeat (2) @(negedge clk);
        #2;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #900000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired, actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule